// File: doc/BRIEF.md
# Reference-Gated Clock Frequency Meter

This block measures how fast its own core clock runs by comparing it with a slow reference clock of known frequency (nominally 32768 Hz) that arrives asynchronously. The reference is brought into the core domain and each rising edge is detected. A divider turns every fourth edge into a time-base tick (8192 Hz). A down-counting gate timer is armed two ticks above the count at which the window opens. The window opens when the gate first reaches its threshold and closes when the gate expires. While the window is open, a prescaled event counter counts core cycles. Because the window both opens and closes on a tick, its length does not depend on where the start pulse falls relative to the reference.

With the default settings (a 58-tick window and a divide-by-177 prescaler), one count is worth almost exactly 25 kHz. A multicycle shift-and-add stage turns the count into a frequency in Hz, rounded to the nearest 0.1 MHz. It also reports a bus frequency, which is either the core frequency or half of it, as chosen by a select input captured at start. A one-cycle done pulse marks valid results. The results then hold until the next measurement completes.

Top module: `freq_meter`

## Requirements
- R1: After reset, busy_o, done_o, ovf_o, count_o, core_hz_o and bus_hz_o are all zero.
- R2: Let T be the reference period in core cycles. At done, count_o equals floor(GATE_TICKS × REF_DIV × T / PRESCALE), because the counter runs for exactly GATE_TICKS time-base ticks and advances once per PRESCALE enabled core cycles.
- R3: The event counter saturates at 2^CNT_W − 1 and never wraps. ovf_o is 1 at done exactly when the unsaturated count would have exceeded that value. The flag is cleared by the next accepted start.
- R4: At done, core_hz_o equals ((count_o + 2) / 4) × STEP_HZ, using integer division.
- R5: At done, bus_hz_o equals core_hz_o when bus_half_i was 0 at the accepted start, and core_hz_o / 2 when it was 1.
- R6: busy_o is 1 from the cycle after an accepted start through the cycle in which done_o is high. done_o is high for exactly one cycle per measurement, and busy_o is 0 in the cycle after it.
- R7: A start_i pulse while busy_o is 1 is ignored. The measurement completes on its original schedule with unchanged results.
- R8: The gate is armed at GATE_TICKS + 1 and counting starts only when it reaches GATE_TICKS − 1. Therefore done follows an accepted start by at least ((GATE_TICKS + 2) × REF_DIV − 1) × T cycles, and the count does not depend on the start phase.
- R9: While idle, count_o, ovf_o, core_hz_o and bus_hz_o stay unchanged, whatever happens on bus_half_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock under measurement |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Slow reference clock, asynchronous |
| start_i | input | 1 | Start pulse, accepted only when idle |
| bus_half_i | input | 1 | 1 = bus runs at half the core clock |
| busy_o | output | 1 | Measurement or conversion in progress |
| done_o | output | 1 | One-cycle pulse: results valid |
| count_o | output | CNT_W | Prescaled core event count |
| ovf_o | output | 1 | Event counter saturated |
| core_hz_o | output | RES_W | Core frequency in Hz |
| bus_hz_o | output | RES_W | Bus frequency in Hz |

## Verification
The point at which results appear depends on the reference phase. The window closes within one reference period of ((GATE_TICKS + 2) × REF_DIV) periods after start, and the conversion then takes CNT_W further cycles. For this reason the bench does not predict a fixed cycle. It samples on falling edges until done_o is seen and checks all results in that cycle. The latency it observed must fall inside the bounds stated in R8. busy_o and done_o are checked in the following cycle. The held results are checked again several idle cycles later, after bus_half_i has been toggled.

// File: rtl/fm_pkg.sv
package fm_pkg;
    typedef enum logic [1:0] {
        FM_IDLE = 2'd0,
        FM_MEAS = 2'd1,
        FM_CALC = 2'd2
    } fm_state_e;
endpackage

// File: rtl/fm_ref_tick.sv
module fm_ref_tick #(
    parameter int REF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    input  logic clr_i,
    output logic tick_o
);
    localparam int DW = (REF_DIV > 2) ? $clog2(REF_DIV) : 1;

    typedef struct packed {
        logic [2:0]    sync;
        logic [DW-1:0] div;
        logic          tick;
    } rt_s;

    rt_s cur_q, nxt_d;
    logic rise;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.sync = {cur_q.sync[1:0], ref_i};
        nxt_d.tick = 1'b0;
        rise       = cur_q.sync[1] & ~cur_q.sync[2];
        if (clr_i) begin
            nxt_d.div = '0;
        end else if (rise) begin
            if (cur_q.div == DW'(REF_DIV - 1)) begin
                nxt_d.div  = '0;
                nxt_d.tick = 1'b1;
            end else begin
                nxt_d.div = cur_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign tick_o = cur_q.tick;

    p_tick_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o) else $error("tick longer than one cycle");
endmodule

// File: rtl/fm_gate.sv
module fm_gate #(
    parameter int GATE_TICKS = 58
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic tick_i,
    output logic open_o,
    output logic term_o
);
    localparam int GW     = $clog2(GATE_TICKS + 2);
    localparam int LOAD   = GATE_TICKS + 1;
    localparam int THRESH = GATE_TICKS - 1;

    typedef struct packed {
        logic [GW-1:0] cnt;
        logic          armed;
        logic          open;
        logic          term;
    } gt_s;

    gt_s cur_q, nxt_d;
    logic [GW-1:0] dec;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.term = 1'b0;
        dec        = cur_q.cnt - 1'b1;
        if (arm_i) begin
            nxt_d.cnt   = GW'(LOAD);
            nxt_d.armed = 1'b1;
            nxt_d.open  = 1'b0;
        end else if (cur_q.armed && tick_i) begin
            if (cur_q.open && cur_q.cnt == '0) begin
                nxt_d.armed = 1'b0;
                nxt_d.open  = 1'b0;
                nxt_d.term  = 1'b1;
            end else begin
                nxt_d.cnt = dec;
                if (dec <= GW'(THRESH)) nxt_d.open = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign open_o = cur_q.open;
    assign term_o = cur_q.term;

    p_open_below_thresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
        open_o |-> (cur_q.cnt <= GW'(THRESH))) else $error("window open above threshold");
    p_term_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        term_o |-> (!open_o && !cur_q.armed)) else $error("window still open at expiry");
    p_term_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        term_o |=> !term_o) else $error("expiry longer than one cycle");
endmodule

// File: rtl/fm_event_cnt.sv
module fm_event_cnt #(
    parameter int PRESCALE = 177,
    parameter int CNT_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o
);
    localparam int PW      = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam int PSC_MAX = PRESCALE - 1;

    typedef struct packed {
        logic [PW-1:0]    psc;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } ec_s;

    ec_s cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (clr_i) begin
            nxt_d = '0;
        end else if (en_i) begin
            if (cur_q.psc == PW'(PSC_MAX)) begin
                nxt_d.psc = '0;
                if (&cur_q.cnt) nxt_d.ovf = 1'b1;
                else            nxt_d.cnt = cur_q.cnt + 1'b1;
            end else begin
                nxt_d.psc = cur_q.psc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign count_o = cur_q.cnt;
    assign ovf_o   = cur_q.ovf;

    p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (&count_o && !clr_i) |=> &count_o) else $error("counter wrapped");
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !clr_i) |=> ovf_o) else $error("overflow flag lost");
    p_hold_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> $stable(count_o)) else $error("count moved while gated off");
endmodule

// File: rtl/fm_scale.sv
module fm_scale #(
    parameter int CNT_W   = 16,
    parameter int RES_W   = 32,
    parameter int STEP_HZ = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             half_i,
    output logic             done_o,
    output logic [RES_W-1:0] core_hz_o,
    output logic [RES_W-1:0] bus_hz_o
);
    localparam int QW = CNT_W - 1;
    localparam int IW = (QW > 2) ? $clog2(QW) : 1;

    typedef struct packed {
        logic             busy;
        logic             half;
        logic [QW-1:0]    mplr;
        logic [RES_W-1:0] mcand;
        logic [RES_W-1:0] acc;
        logic [IW-1:0]    idx;
        logic             done;
        logic [RES_W-1:0] core;
        logic [RES_W-1:0] bus;
    } sc_s;

    sc_s cur_q, nxt_d;
    logic [CNT_W:0]   rounded;
    logic [RES_W-1:0] acc_nx;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        rounded    = {1'b0, count_i} + (CNT_W+1)'(2);
        acc_nx     = cur_q.acc + (cur_q.mplr[0] ? cur_q.mcand : '0);
        if (go_i && !cur_q.busy) begin
            nxt_d.busy  = 1'b1;
            nxt_d.half  = half_i;
            nxt_d.mplr  = QW'(rounded >> 2);
            nxt_d.mcand = RES_W'(STEP_HZ);
            nxt_d.acc   = '0;
            nxt_d.idx   = '0;
        end else if (cur_q.busy) begin
            nxt_d.acc   = acc_nx;
            nxt_d.mcand = cur_q.mcand << 1;
            nxt_d.mplr  = cur_q.mplr >> 1;
            if (cur_q.idx == IW'(QW - 1)) begin
                nxt_d.busy = 1'b0;
                nxt_d.done = 1'b1;
                nxt_d.core = acc_nx;
                nxt_d.bus  = cur_q.half ? (acc_nx >> 1) : acc_nx;
            end else begin
                nxt_d.idx = cur_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign done_o    = cur_q.done;
    assign core_hz_o = cur_q.core;
    assign bus_hz_o  = cur_q.bus;

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o) else $error("done longer than one cycle");
    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_q.busy && !go_i) |=> ($stable(core_hz_o) && $stable(bus_hz_o)))
        else $error("result changed while idle");
    p_bus_not_above_core_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (bus_hz_o <= core_hz_o)) else $error("bus above core");
endmodule

// File: rtl/freq_meter.sv
module freq_meter #(
    parameter int REF_DIV    = 4,
    parameter int GATE_TICKS = 58,
    parameter int PRESCALE   = 177,
    parameter int CNT_W      = 16,
    parameter int RES_W      = 32,
    parameter int STEP_HZ    = 100000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_clk_i,
    input  logic             start_i,
    input  logic             bus_half_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o,
    output logic [RES_W-1:0] core_hz_o,
    output logic [RES_W-1:0] bus_hz_o
);
    import fm_pkg::*;

    typedef struct packed {
        fm_state_e state;
        logic      half;
    } top_s;

    top_s cur_q, nxt_d;
    logic kick, tick, gate_open, gate_term, calc_go, calc_done;

    always_comb begin
        nxt_d   = cur_q;
        kick    = (cur_q.state == FM_IDLE) && start_i;
        calc_go = (cur_q.state == FM_MEAS) && gate_term;
        unique case (cur_q.state)
            FM_IDLE: if (kick) begin
                nxt_d.state = FM_MEAS;
                nxt_d.half  = bus_half_i;
            end
            FM_MEAS: if (gate_term) nxt_d.state = FM_CALC;
            FM_CALC: if (calc_done) nxt_d.state = FM_IDLE;
            default: nxt_d.state = FM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{state: FM_IDLE, half: 1'b0};
        else        cur_q <= nxt_d;
    end

    fm_ref_tick #(.REF_DIV(REF_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .ref_i(ref_clk_i), .clr_i(kick), .tick_o(tick)
    );

    fm_gate #(.GATE_TICKS(GATE_TICKS)) u_gate (
        .clk(clk), .rst_n(rst_n), .arm_i(kick), .tick_i(tick),
        .open_o(gate_open), .term_o(gate_term)
    );

    fm_event_cnt #(.PRESCALE(PRESCALE), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(kick), .en_i(gate_open),
        .count_o(count_o), .ovf_o(ovf_o)
    );

    fm_scale #(.CNT_W(CNT_W), .RES_W(RES_W), .STEP_HZ(STEP_HZ)) u_scale (
        .clk(clk), .rst_n(rst_n), .go_i(calc_go), .count_i(count_o), .half_i(cur_q.half),
        .done_o(calc_done), .core_hz_o(core_hz_o), .bus_hz_o(bus_hz_o)
    );

    assign busy_o = (cur_q.state != FM_IDLE);
    assign done_o = calc_done;

    p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.state == FM_MEAS && start_i && !gate_term) |=> (cur_q.state == FM_MEAS))
        else $error("start restarted a running measurement");
    p_done_ends_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o) else $error("busy after done");
    p_count_frozen_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(count_o) && $stable(ovf_o)))
        else $error("count moved while idle");
    p_window_only_measuring_r8: assert property (@(posedge clk) disable iff (!rst_n)
        gate_open |-> (cur_q.state == FM_MEAS)) else $error("window open outside measurement");
endmodule

// File: tb/freq_meter_bench.sv
module freq_meter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int G   = 4;
    localparam int RD  = 4;
    localparam int P   = 3;
    localparam int W   = 8;
    localparam int RW  = 32;
    localparam int STP = 100000;
    localparam int CMAX = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_clk = 1'b0;
    logic start = 1'b0;
    logic bus_half = 1'b0;
    logic busy, done, ovf;
    logic [W-1:0]  count;
    logic [RW-1:0] core_hz, bus_hz;

    int n_checks = 0;
    int n_fail = 0;
    int hi_len = 2;
    int lo_len = 2;
    int cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    freq_meter #(.REF_DIV(RD), .GATE_TICKS(G), .PRESCALE(P), .CNT_W(W),
                 .RES_W(RW), .STEP_HZ(STP)) u_freq_meter (
        .clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .start_i(start),
        .bus_half_i(bus_half), .busy_o(busy), .done_o(done), .count_o(count),
        .ovf_o(ovf), .core_hz_o(core_hz), .bus_hz_o(bus_hz)
    );

    initial forever begin
        repeat (hi_len) @(negedge clk);
        ref_clk = 1'b1;
        repeat (lo_len) @(negedge clk);
        ref_clk = 1'b0;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        check(1'b0, "watchdog", cycles, 0);
        finish_run();
    end

    task automatic run_meas(input int hi, input int lo, input bit half,
                            input int offset, input int restart_at);
        int t, n, ecnt, lat, lo_b, hi_b;
        bit eovf, busy_ok;
        longint ecore, ebus;
        logic [RW-1:0] hold_core, hold_bus;
        logic [W-1:0] hold_cnt;
        hi_len = hi;
        lo_len = lo;
        t = hi + lo;
        repeat (2 * t + 2 + offset) @(negedge clk);
        n = G * RD * t;
        ecnt = n / P;
        eovf = (ecnt > CMAX);
        if (eovf) ecnt = CMAX;
        ecore = longint'((ecnt + 2) / 4) * STP;
        ebus = half ? ecore / 2 : ecore;
        lo_b = ((G + 2) * RD - 1) * t;
        hi_b = (G + 2) * RD * t + t + W + 12;
        bus_half = half;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        bus_half = ~half;
        lat = 1;
        busy_ok = 1'b1;
        while (!done && lat < 20000) begin
            if (!busy) busy_ok = 1'b0;
            start = (restart_at != 0 && lat == restart_at);
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        check(busy_ok && busy, "R6 busy during run", busy, 1);
        check(done == 1'b1, "R6 done seen", done, 1);
        check(count == W'(ecnt), "R2 count", count, ecnt);
        check(ovf == eovf, "R3 overflow", ovf, eovf);
        check(core_hz == RW'(ecore), "R4 core_hz", core_hz, ecore);
        check(bus_hz == RW'(ebus), "R5 bus_hz", bus_hz, ebus);
        check(lat >= lo_b, "R8 latency lower", lat, lo_b);
        check(lat <= hi_b, restart_at != 0 ? "R7 latency upper" : "R8 latency upper", lat, hi_b);
        @(negedge clk);
        check(!done && !busy, "R6 done/busy drop", {done, busy}, 0);
        hold_core = core_hz;
        hold_bus = bus_hz;
        hold_cnt = count;
        repeat (3) @(negedge clk);
        bus_half = half;
        repeat (3) @(negedge clk);
        check(core_hz == hold_core && bus_hz == hold_bus && count == hold_cnt && !done,
              "R9 hold idle", core_hz, hold_core);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !ovf && count == '0 && core_hz == '0 && bus_hz == '0,
              "R1 in reset", core_hz, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !done && count == '0 && core_hz == '0,
              "R1 after reset", count, 0);

        // R2/R4/R5 sweep over reference shapes and bus select
        for (int h = 1; h <= 6; h++) begin
            for (int l = 1; l <= 6; l++) begin
                run_meas(h, l, bit'((h + l) & 1), (h * 3 + l) % 5, 0);
            end
        end
        // R8 start-phase independence
        for (int off = 0; off < 10; off++) run_meas(3, 4, 1'b0, off, 0);
        // R3 boundary: just below and at saturation, and well beyond
        run_meas(24, 23, 1'b0, 0, 0);
        run_meas(24, 24, 1'b1, 1, 0);
        run_meas(30, 30, 1'b0, 2, 0);
        // R7 start pulses while busy, early and late in the run
        run_meas(5, 5, 1'b1, 0, 7);
        run_meas(5, 5, 1'b0, 3, (G + 1) * RD * 10);
        finish_run();
    end
endmodule